// File: doc/BRIEF.md
# Three-Axis Sensor Register File

This block holds the host-visible registers of a three-axis sensor. A measurement engine pulses `smp_valid` with fresh X, Y and Z samples (16-bit two's complement), and all three are captured at the same clock edge. A host reaches the registers through a byte-wide port. `host_ld` loads an address pointer. Each `host_rd` or `host_wr` strobe then accesses the byte at the pointer and moves the pointer on, so a host can run bursts across the map. Read data is registered and appears on `host_rdata` one cycle after the strobe.

A status byte reports fresh data and lost data for each axis and for the set of three. Reading an axis high byte clears that axis's flags. The set-level flags clear only once every axis high byte has been read since the latest capture. That tracking is a two-state machine. `SET_IDLE` means no capture is pending. A capture moves it to `SET_OPEN` from either state, and the read-tracking mask restarts. When the mask of high bytes read covers all three axes, `SET_OPEN` returns to `SET_IDLE`. Reading a high byte also saves the matching low byte, so the pair always comes from one sample. A fast mode bit makes bursts visit only the status and high bytes.

Top module: `sns_regfile`

## Requirements
- R1: Address 0x07 reads the fixed identity 0xC4. Address 0x0F reads `temp_in`. Any address above 0x11 reads 0x00.
- R2: A pulse on `smp_valid` captures `smp_x`, `smp_y` and `smp_z` together. The high bytes (bits 15:8) read at 0x01 (X), 0x03 (Y) and 0x05 (Z).
- R3: Status bits 0, 1 and 2 are the ready flags for X, Y and Z. A capture sets all three. A read of an axis high byte clears that axis's ready flag. When a capture and a high-byte read occur at the same edge, the read returns the old sample and the ready flag ends up set.
- R4: Status bits 4, 5 and 6 are the overwrite flags for X, Y and Z. A capture sets an axis's overwrite flag if that axis's ready flag was set and its high byte is not being read at that edge. A read of the axis high byte clears the flag.
- R5: Status bit 3 (set ready) is set by every capture. Status bit 7 (set overwrite) is set by a capture that leaves any overwrite flag set. Both clear only after all three high bytes have been read since the latest capture, and a new capture restarts that tracking.
- R6: `host_ld` loads the pointer from `host_addr`. Each accepted read or write moves the pointer to the next address. From 0x11 or above, the pointer returns to 0x00.
- R7: When control byte 0x10 bit 2 (fast) is set, the pointer moves from 0x01 to 0x03, from 0x03 to 0x05, and from 0x05 back to 0x00. All other addresses step as in R6.
- R8: Addresses 0x02, 0x04 and 0x06 return the low byte that was saved at the most recent read of the same axis's high byte. After reset they return 0x00.
- R9: Address 0x08 reads 0 when control 0x10 bit 0 (active) is clear. It reads 1 when active is set and control 0x11 bit 5 (raw) is set. It reads 2 when active is set and raw is clear. Bits 7:2 always read 0.
- R10: Writes to 0x09–0x0E store the offset bytes, as high/low pairs for X, Y and Z. Each low byte keeps bits 7:1, and its bit 0 reads 0. The offset output of each axis is {high[7], high, low[7:1]}. Control 0x10 stores all 8 bits. Control 0x11 stores only bits 7, 5 and 4. Writes to any other address change nothing.
- R11: After reset, `host_rdata`, the pointer, all flags, the saved low bytes, the offsets and both control bytes are zero. `host_rdata` holds its value until the next accepted read.
- R12: In a cycle with `host_ld`, the read and write strobes are ignored. When both read and write strobes are high, the read is done, the write is dropped, and the pointer moves once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ld | input | 1 | Load the pointer from host_addr |
| host_addr | input | 8 | Start address of a burst |
| host_rd | input | 1 | Read strobe, one byte per cycle |
| host_wr | input | 1 | Write strobe, one byte per cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| smp_valid | input | 1 | Capture pulse from the measurement engine |
| smp_x | input | 16 | X sample |
| smp_y | input | 16 | Y sample |
| smp_z | input | 16 | Z sample |
| temp_in | input | 8 | Die temperature shown at 0x0F |
| cfg1_o | output | 8 | Control byte at 0x10 |
| cfg2_o | output | 8 | Control byte at 0x11 (bits 7, 5, 4) |
| off_x_o | output | 16 | Sign-extended X offset |
| off_y_o | output | 16 | Sign-extended Y offset |
| off_z_o | output | 16 | Sign-extended Z offset |

## Verification
The hardest case to reach is a capture that lands at the very edge where the host reads an axis high byte. In that case the read must return the old sample, the new capture must win the ready flag, and that axis must not report an overwrite. The stimulus gets there by loading the pointer to the X high byte and then raising `host_rd` and `smp_valid` in the same cycle. A second awkward case is a capture that arrives between a high-byte read and its low-byte read. Here the saved low byte must survive, and the set-level tracking must forget the read made before the capture. The stimulus reaches it by splitting a burst around a capture pulse.

// File: rtl/sns_pkg.sv
package sns_pkg;

    localparam int BYTE_W = 8;
    localparam int SMP_W  = 2 * BYTE_W;
    localparam int AXES   = 3;
    localparam int LOW_W  = BYTE_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;

    // Address map; high/low and offset pairs are laid out per axis
    localparam byte_t A_STAT = 8'h00;
    localparam byte_t A_XH   = 8'h01;
    localparam byte_t A_YH   = 8'h03;
    localparam byte_t A_ZH   = 8'h05;
    localparam byte_t A_ID   = 8'h07;
    localparam byte_t A_MODE = 8'h08;
    localparam byte_t A_OFF0 = 8'h09;
    localparam byte_t A_TEMP = 8'h0F;
    localparam byte_t A_CFG1 = 8'h10;
    localparam byte_t A_CFG2 = 8'h11;

    localparam byte_t ID_VAL    = 8'hC4;
    localparam byte_t CFG2_KEEP = 8'hB0;

    localparam int CFG1_ACTIVE = 0;
    localparam int CFG1_FAST   = 2;
    localparam int CFG2_RAW    = 5;

    typedef enum logic [0:0] {
        SET_IDLE = 1'b0,
        SET_OPEN = 1'b1
    } set_state_e;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_RAW     = 2'd1,
        MODE_CORR    = 2'd2
    } mode_e;

endpackage

// File: rtl/sns_ptr.sv
module sns_ptr
    import sns_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ld,
    input  byte_t ld_addr,
    input  logic  step,
    input  logic  fast,
    output byte_t ptr
);

    byte_t ptr_q;
    byte_t ptr_n;

    // Successor address for one burst step
    always_comb begin
        if (fast && (ptr_q == A_XH || ptr_q == A_YH)) begin
            ptr_n = ptr_q + byte_t'(2);
        end else if (fast && ptr_q == A_ZH) begin
            ptr_n = A_STAT;
        end else if (ptr_q >= A_CFG2) begin
            ptr_n = A_STAT;
        end else begin
            ptr_n = ptr_q + byte_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= A_STAT;
        end else if (ld) begin
            ptr_q <= ld_addr;
        end else if (step) begin
            ptr_q <= ptr_n;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/sns_status.sv
module sns_status
    import sns_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            latch,
    input  logic [AXES-1:0] hi_rd,
    output byte_t           status
);

    logic [AXES-1:0] rdy_q;
    logic [AXES-1:0] ovw_q;
    logic [AXES-1:0] ovw_n;
    logic [AXES-1:0] seen_q;
    logic            all_seen;
    logic            sum_ovw_q;
    set_state_e      state_q;
    set_state_e      state_n;

    // Per-axis ready and overwrite flags
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        always_comb begin
            ovw_n[a] = hi_rd[a] ? 1'b0 : (ovw_q[a] | rdy_q[a]);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rdy_q[a] <= 1'b0;
                ovw_q[a] <= 1'b0;
            end else if (latch) begin
                rdy_q[a] <= 1'b1;
                ovw_q[a] <= ovw_n[a];
            end else if (hi_rd[a]) begin
                rdy_q[a] <= 1'b0;
                ovw_q[a] <= 1'b0;
            end
        end
    end

    assign all_seen = &(seen_q | hi_rd);

    // Set-level tracker: next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SET_IDLE: begin
                if (latch) state_n = SET_OPEN;
            end
            SET_OPEN: begin
                if (latch)         state_n = SET_OPEN;
                else if (all_seen) state_n = SET_IDLE;
            end
            default: state_n = SET_IDLE;
        endcase
    end

    // Set-level tracker: state register and read mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SET_IDLE;
            seen_q  <= '0;
        end else begin
            state_q <= state_n;
            if (latch || state_n == SET_IDLE) begin
                seen_q <= '0;
            end else begin
                seen_q <= seen_q | hi_rd;
            end
        end
    end

    // Set-level tracker: overwrite summary output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_ovw_q <= 1'b0;
        end else if (latch) begin
            sum_ovw_q <= |ovw_n;
        end else if (state_q == SET_OPEN && state_n == SET_IDLE) begin
            sum_ovw_q <= 1'b0;
        end
    end

    assign status = {sum_ovw_q, ovw_q, (state_q == SET_OPEN), rdy_q};

endmodule

// File: rtl/sns_store.sv
module sns_store
    import sns_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       latch,
    input  logic [AXES-1:0][SMP_W-1:0] smp,
    input  byte_t                      temp,
    input  byte_t                      ptr,
    input  logic                       rd_go,
    input  logic                       wr_go,
    input  byte_t                      wdata,
    input  byte_t                      status,
    output byte_t                      rdata,
    output byte_t                      cfg1,
    output byte_t                      cfg2,
    output logic [AXES-1:0][SMP_W-1:0] offset,
    output logic [AXES-1:0]            hi_rd
);

    logic [AXES-1:0][SMP_W-1:0] smp_q;
    byte_t                      shadow_q [AXES];
    byte_t                      offh_q   [AXES];
    logic [LOW_W-1:0]           offl_q   [AXES];
    byte_t                      cfg1_q;
    byte_t                      cfg2_q;
    byte_t                      rdata_q;
    byte_t                      rd_val;
    byte_t                      mode_byte;
    mode_e                      mode;

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        localparam byte_t HI_A  = byte_t'(A_XH + 2 * a);
        localparam byte_t OFH_A = byte_t'(A_OFF0 + 2 * a);

        assign hi_rd[a] = rd_go && (ptr == HI_A);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                smp_q[a] <= '0;
            end else if (latch) begin
                smp_q[a] <= smp[a];
            end
        end

        // Low byte saved when the high byte leaves
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[a] <= '0;
            end else if (hi_rd[a]) begin
                shadow_q[a] <= smp_q[a][BYTE_W-1:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                offh_q[a] <= '0;
                offl_q[a] <= '0;
            end else if (wr_go) begin
                if (ptr == OFH_A)                offh_q[a] <= wdata;
                if (ptr == OFH_A + byte_t'(1))   offl_q[a] <= wdata[BYTE_W-1:1];
            end
        end

        assign offset[a] = {offh_q[a][BYTE_W-1], offh_q[a], offl_q[a]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg1_q <= '0;
            cfg2_q <= '0;
        end else if (wr_go) begin
            if (ptr == A_CFG1) cfg1_q <= wdata;
            if (ptr == A_CFG2) cfg2_q <= wdata & CFG2_KEEP;
        end
    end

    always_comb begin
        if (!cfg1_q[CFG1_ACTIVE])   mode = MODE_STANDBY;
        else if (cfg2_q[CFG2_RAW])  mode = MODE_RAW;
        else                        mode = MODE_CORR;
        mode_byte = {{(BYTE_W-2){1'b0}}, mode};
    end

    // Read multiplexer
    always_comb begin
        rd_val = '0;
        if (ptr == A_STAT) rd_val = status;
        if (ptr == A_ID)   rd_val = ID_VAL;
        if (ptr == A_MODE) rd_val = mode_byte;
        if (ptr == A_TEMP) rd_val = temp;
        if (ptr == A_CFG1) rd_val = cfg1_q;
        if (ptr == A_CFG2) rd_val = cfg2_q;
        for (int a = 0; a < AXES; a++) begin
            if (ptr == byte_t'(A_XH + 2 * a))
                rd_val = smp_q[a][SMP_W-1:BYTE_W];
            if (ptr == byte_t'(A_XH + 2 * a + 1))
                rd_val = shadow_q[a];
            if (ptr == byte_t'(A_OFF0 + 2 * a))
                rd_val = offh_q[a];
            if (ptr == byte_t'(A_OFF0 + 2 * a + 1))
                rd_val = {offl_q[a], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_go) begin
            rdata_q <= rd_val;
        end
    end

    assign rdata = rdata_q;
    assign cfg1  = cfg1_q;
    assign cfg2  = cfg2_q;

endmodule

// File: rtl/sns_regfile.sv
module sns_regfile
    import sns_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_ld,
    input  logic [7:0]  host_addr,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        smp_valid,
    input  logic [15:0] smp_x,
    input  logic [15:0] smp_y,
    input  logic [15:0] smp_z,
    input  logic [7:0]  temp_in,
    output logic [7:0]  cfg1_o,
    output logic [7:0]  cfg2_o,
    output logic [15:0] off_x_o,
    output logic [15:0] off_y_o,
    output logic [15:0] off_z_o
);

    logic                       rd_go;
    logic                       wr_go;
    byte_t                      ptr_q;
    byte_t                      status_q;
    byte_t                      cfg1;
    logic [AXES-1:0]            hi_rd;
    logic [AXES-1:0][SMP_W-1:0] smp_bus;
    logic [AXES-1:0][SMP_W-1:0] off_bus;

    // Loading wins over access; reading wins over writing
    assign rd_go = host_rd && !host_ld;
    assign wr_go = host_wr && !host_ld && !host_rd;

    assign smp_bus = {smp_z, smp_y, smp_x};

    sns_ptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (host_ld),
        .ld_addr (host_addr),
        .step    (rd_go || wr_go),
        .fast    (cfg1[CFG1_FAST]),
        .ptr     (ptr_q)
    );

    sns_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .latch  (smp_valid),
        .hi_rd  (hi_rd),
        .status (status_q)
    );

    sns_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .latch  (smp_valid),
        .smp    (smp_bus),
        .temp   (temp_in),
        .ptr    (ptr_q),
        .rd_go  (rd_go),
        .wr_go  (wr_go),
        .wdata  (host_wdata),
        .status (status_q),
        .rdata  (host_rdata),
        .cfg1   (cfg1),
        .cfg2   (cfg2_o),
        .offset (off_bus),
        .hi_rd  (hi_rd)
    );

    assign cfg1_o  = cfg1;
    assign off_x_o = off_bus[0];
    assign off_y_o = off_bus[1];
    assign off_z_o = off_bus[2];

endmodule

// File: rtl/sns_regfile_chk.sv
module sns_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_ld,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_addr,
    input logic [7:0] host_rdata,
    input logic       smp_valid,
    input logic [7:0] cfg1,
    input logic [7:0] cfg2,
    input logic [7:0] ptr,
    input logic [7:0] status
);

    a_r3_capture_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (status[2:0] == 3'b111) && status[3]);

    a_r4_unread_capture_overwrites: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !host_rd && status[0]) |=> status[4]);

    a_r5_ready_summary_covers: assert property (@(posedge clk) disable iff (!rst_n)
        !status[3] |-> (status[2:0] == 3'b000));

    a_r5_overwrite_summary_covers: assert property (@(posedge clk) disable iff (!rst_n)
        !status[7] |-> (status[6:4] == 3'b000));

    a_r6_load_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        host_ld |=> ptr == $past(host_addr));

    a_r6_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ld && (host_rd || host_wr) && !cfg1[2] && ptr == 8'h11) |=> ptr == 8'h00);

    a_r7_fast_skip_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ld && host_rd && cfg1[2] && ptr == 8'h01) |=> ptr == 8'h03);

    a_r7_fast_wrap_status: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ld && host_rd && cfg1[2] && ptr == 8'h05) |=> ptr == 8'h00);

    a_r9_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ld && host_rd && ptr == 8'h08) |=> (host_rdata[7:2] == 6'd0) && (host_rdata[1:0] != 2'd3));

    a_r12_read_beats_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ld && host_rd && host_wr) |=> $stable(cfg1) && $stable(cfg2));

endmodule

bind sns_regfile sns_regfile_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ld    (host_ld),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .smp_valid  (smp_valid),
    .cfg1       (cfg1_o),
    .cfg2       (cfg2_o),
    .ptr        (ptr_q),
    .status     (status_q)
);

// File: tb/sim_sns_regfile.sv
module sim_sns_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_ld, host_rd, host_wr, smp_valid;
    logic [7:0]  host_addr, host_wdata, temp_in;
    logic [15:0] smp_x, smp_y, smp_z;
    logic [7:0]  host_rdata, cfg1_o, cfg2_o;
    logic [15:0] off_x_o, off_y_o, off_z_o;

    always #5 clk = ~clk;

    sns_regfile u0 (
        .clk(clk), .rst_n(rst_n), .host_ld(host_ld), .host_addr(host_addr),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .smp_valid(smp_valid), .smp_x(smp_x),
        .smp_y(smp_y), .smp_z(smp_z), .temp_in(temp_in), .cfg1_o(cfg1_o),
        .cfg2_o(cfg2_o), .off_x_o(off_x_o), .off_y_o(off_y_o), .off_z_o(off_z_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mptr, exp_rd, last_addr, c1, c2, sovw, srdy;
    int msmp[3], mshadow[3], moh[3], mol[3], mrdy[3], movw[3], mseen[3];

    function automatic int m_status();
        int s = 0;
        for (int a = 0; a < 3; a++) begin
            s += mrdy[a] << a;
            s += movw[a] << (a + 4);
        end
        return s + (srdy << 3) + (sovw << 7);
    endfunction

    function automatic int m_mode();
        if ((c1 & 1) == 0) return 0;
        return ((c2 & 8'h20) != 0) ? 1 : 2;
    endfunction

    function automatic int m_read(input int p);
        if (p == 0) return m_status();
        if (p >= 1 && p <= 6) return ((p % 2) == 1) ? (msmp[(p-1)/2] >> 8) : mshadow[(p-2)/2];
        if (p == 7) return 8'hC4;
        if (p == 8) return m_mode();
        if (p >= 9 && p <= 14) return ((p % 2) == 1) ? moh[(p-9)/2] : mol[(p-10)/2];
        if (p == 15) return int'(temp_in);
        if (p == 16) return c1;
        if (p == 17) return c2;
        return 0;
    endfunction

    function automatic int m_next(input int p, input int fast);
        if (fast != 0 && (p == 1 || p == 3)) return p + 2;
        if (fast != 0 && p == 5) return 0;
        if (p >= 17) return 0;
        return p + 1;
    endfunction

    function automatic int m_off(input int a);
        int v = (moh[a] << 7) | (mol[a] >> 1);
        if ((moh[a] & 8'h80) != 0) v |= 16'h8000;
        return v;
    endfunction

    function automatic string rtag(input int p);
        if (p == 0) return "R4";
        if (p == 1 || p == 3 || p == 5) return "R2";
        if (p == 2 || p == 4 || p == 6) return "R8";
        if (p == 8) return "R9";
        if ((p >= 9 && p <= 14) || p == 16 || p == 17) return "R10";
        return "R1";
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mptr = 0; exp_rd = 0; last_addr = 7; c1 = 0; c2 = 0; sovw = 0; srdy = 0;
            for (int a = 0; a < 3; a++) begin
                msmp[a] = 0; mshadow[a] = 0; moh[a] = 0; mol[a] = 0;
                mrdy[a] = 0; movw[a] = 0; mseen[a] = 0;
            end
        end else begin
            bit rdgo, wrgo;
            int hr[3];
            int sm[3];
            int anyo;
            sm[0] = int'(smp_x); sm[1] = int'(smp_y); sm[2] = int'(smp_z);
            rdgo = host_rd && !host_ld;
            wrgo = host_wr && !host_ld && !host_rd;
            if (rdgo) begin
                exp_rd = m_read(mptr);
                last_addr = mptr;
            end
            for (int a = 0; a < 3; a++) begin
                hr[a] = (rdgo && mptr == 1 + 2 * a) ? 1 : 0;
                if (hr[a] != 0) mshadow[a] = msmp[a] & 8'hFF;
            end
            if (smp_valid) begin
                anyo = 0;
                for (int a = 0; a < 3; a++) begin
                    movw[a] = (hr[a] != 0) ? 0 : (movw[a] | mrdy[a]);
                    anyo |= movw[a];
                    mrdy[a] = 1;
                    mseen[a] = 0;
                    msmp[a] = sm[a];
                end
                srdy = 1;
                sovw = anyo;
            end else begin
                for (int a = 0; a < 3; a++) begin
                    if (hr[a] != 0) begin
                        mrdy[a] = 0; movw[a] = 0; mseen[a] = 1;
                    end
                end
                if (srdy != 0 && mseen[0] != 0 && mseen[1] != 0 && mseen[2] != 0) begin
                    srdy = 0; sovw = 0;
                    for (int a = 0; a < 3; a++) mseen[a] = 0;
                end
            end
            if (wrgo) begin
                for (int a = 0; a < 3; a++) begin
                    if (mptr == 9 + 2 * a)  moh[a] = int'(host_wdata);
                    if (mptr == 10 + 2 * a) mol[a] = int'(host_wdata) & 8'hFE;
                end
                if (mptr == 16) c1 = int'(host_wdata);
                if (mptr == 17) c2 = int'(host_wdata) & 8'hB0;
            end
            if (host_ld) mptr = int'(host_addr);
            else if (rdgo || wrgo) mptr = m_next(mptr, c1 & 4);
        end
    end

    // Compare against the model every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rtag(last_addr), int'(host_rdata), exp_rd);
            chk("R10 cfg1", int'(cfg1_o), c1);
            chk("R10 cfg2", int'(cfg2_o), c2);
            chk("R10 offx", int'(off_x_o), m_off(0));
            chk("R10 offy", int'(off_y_o), m_off(1));
            chk("R10 offz", int'(off_z_o), m_off(2));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic ld(input logic [7:0] a);
        host_ld = 1'b1; host_addr = a;
        @(negedge clk);
        host_ld = 1'b0;
    endtask

    task automatic rdchk(input string tag, input int exp);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        chk(tag, int'(host_rdata), exp);
    endtask

    task automatic wr(input logic [7:0] d);
        host_wr = 1'b1; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic cap(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
        smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; host_ld = 0; host_rd = 0; host_wr = 0; smp_valid = 0;
        host_addr = 0; host_wdata = 0; temp_in = 8'h5A;
        smp_x = 0; smp_y = 0; smp_z = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 rdata", int'(host_rdata), 0);
        chk("R11 cfg1", int'(cfg1_o), 0);
        chk("R11 offx", int'(off_x_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 fixed and live bytes, R9 standby
        ld(8'h07); rdchk("R1 id", 8'hC4); rdchk("R9 standby", 0);
        ld(8'h0F); rdchk("R1 temp", 8'h5A);
        ld(8'h30); rdchk("R1 unmapped", 0);

        // R2 capture, R8 low bytes, R6 increment
        cap(16'h1234, 16'hABCD, 16'h8001);
        ld(8'h00); rdchk("R3 ready", 8'h0F);
        rdchk("R2 xh", 8'h12); rdchk("R8 xl", 8'h34);
        rdchk("R2 yh", 8'hAB); rdchk("R8 yl", 8'hCD);
        rdchk("R2 zh", 8'h80); rdchk("R8 zl", 8'h01);
        rdchk("R6 step", 8'hC4);
        ld(8'h00); rdchk("R5 cleared", 0);

        // R4 overwrite
        cap(16'h1111, 16'h2222, 16'h3333);
        cap(16'h4444, 16'h5555, 16'h6666);
        ld(8'h00); rdchk("R4 all", 8'hFF);
        ld(8'h01); rdchk("R2 xh", 8'h44);
        ld(8'h00); rdchk("R4 x cleared", 8'hEE);
        ld(8'h03); rdchk("R2 yh", 8'h55);
        ld(8'h05); rdchk("R2 zh", 8'h66);
        ld(8'h00); rdchk("R5 all read", 0);

        // R8 saved low byte, R5 tracking restart
        cap(16'h0102, 16'h0304, 16'h0506);
        ld(8'h01); rdchk("R2 xh", 8'h01);
        cap(16'h7788, 16'h99AA, 16'hBBCC);
        rdchk("R8 saved", 8'h02);
        ld(8'h00); rdchk("R5 restart", 8'hEF);
        ld(8'h03); rdchk("R2 yh", 8'h99); rdchk("R8 yl", 8'hAA); rdchk("R2 zh", 8'hBB);
        ld(8'h00); rdchk("R5 x pending", 8'h89);
        ld(8'h01); rdchk("R2 xh", 8'h77);
        ld(8'h00); rdchk("R5 done", 0);

        // R3 capture at the edge of a high-byte read
        cap(16'h0A0B, 16'h0C0D, 16'h0E0F);
        ld(8'h01);
        host_rd = 1'b1; smp_valid = 1'b1;
        smp_x = 16'hC0C1; smp_y = 16'hC2C3; smp_z = 16'hC4C5;
        @(negedge clk);
        host_rd = 1'b0; smp_valid = 1'b0;
        chk("R3 old sample", int'(host_rdata), 8'h0A);
        ld(8'h00); rdchk("R3 same edge", 8'hEF);
        rdchk("R2 xh", 8'hC0); rdchk("R8 xl", 8'hC1);
        ld(8'h03); rdchk("R2 yh", 8'hC2);
        ld(8'h05); rdchk("R2 zh", 8'hC4);
        ld(8'h00); rdchk("R5 done", 0);

        // R9 modes, R10 control masks
        ld(8'h10); wr(8'h05);
        ld(8'h08); rdchk("R9 corrected", 2);
        ld(8'h11); wr(8'hFF);
        ld(8'h11); rdchk("R10 cfg2 mask", 8'hB0);
        ld(8'h08); rdchk("R9 raw", 1);

        // R7 fast burst
        cap(16'h1100, 16'h2200, 16'h3300);
        ld(8'h00);
        rdchk("R7 status", 8'h0F); rdchk("R7 xh", 8'h11);
        rdchk("R7 yh", 8'h22); rdchk("R7 zh", 8'h33); rdchk("R7 wrap", 0);

        // R12 read beats write; load beats read
        ld(8'h10);
        host_rd = 1'b1; host_wr = 1'b1; host_wdata = 8'h00;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        chk("R12 read done", int'(host_rdata), 8'h05);
        chk("R12 write dropped", int'(cfg1_o), 8'h05);
        rdchk("R12 one step", 8'hB0);
        ld(8'h10); wr(8'h00);
        ld(8'h11); rdchk("R6 top", 8'hB0); rdchk("R6 wrap", 0);
        ld(8'h08); rdchk("R9 standby", 0);
        host_ld = 1'b1; host_addr = 8'h07; host_rd = 1'b1;
        @(negedge clk);
        host_ld = 1'b0; host_rd = 1'b0;
        chk("R12 load wins", int'(host_rdata), 0);
        rdchk("R12 loaded", 8'hC4);

        // R10 offsets and ignored writes
        ld(8'h09);
        wr(8'h81); wr(8'hFF); wr(8'h01); wr(8'h02); wr(8'h7F); wr(8'h03);
        chk("R10 offx", int'(off_x_o), 16'hC0FF);
        chk("R10 offy", int'(off_y_o), 16'h0081);
        chk("R10 offz", int'(off_z_o), 16'h3F81);
        ld(8'h0A); rdchk("R10 low bit0", 8'hFE);
        ld(8'h07); wr(8'h00);
        ld(8'h07); rdchk("R10 id kept", 8'hC4);
        ld(8'h01); wr(8'h55);
        ld(8'h01); rdchk("R10 data kept", 8'h11);

        @(negedge clk);
        finish_run();
    end

endmodule